// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm

This block keeps the time of day in three counters. The finest counter steps in half-seconds, and the others hold minutes and hours across a 24-hour day. An external prescaler supplies a tick enable. The block counts `SUB_TICKS` of those ticks to make one half-second step, so it needs no knowledge of the oscillator frequency.

On each step it can raise a one-cycle interval interrupt. The rate is chosen by software: every half-second, every second, every minute, every hour or once a day. A separate alarm interrupt pulses when the freshly stepped time equals the programmed alarm half-second, minute and hour.

Software reads and writes the counters, the alarm fields and a small control register through a flat address/data register port. Reads are combinational.

Top module: `tod_alarm_clock`

## Requirements
- R1: After reset, every register reads 0 and both interrupt outputs are low.
- R2: The half-second counter advances by one only when the `SUB_TICKS`-th `tick_en` pulse arrives (default 4). With `tick_en` low, or after fewer pulses, the time does not change. `SUB_TICKS` must be at least 2.
- R3: The half-second counter wraps from 119 to 0 and carries into the minute counter. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0.
- R4: Control register bits [2:0] select the interval interrupt. 1 pulses on every step. 2 pulses on steps that land on an even half-second count (whole seconds). 3 pulses on the half-second wrap. 4 pulses on the hour rollover. 5 pulses once a day. The pulse lasts one cycle and coincides with the new time becoming readable.
- R5: With selection 5, the interval pulse fires only on the step from 23:59 half 119 to 00:00 half 0.
- R6: When control bit 3 is set, `irq_alarm` pulses for one cycle on the step whose new time equals all three alarm fields. It does not pulse again before the next step.
- R7: With control bit 3 clear, no alarm pulse occurs even when the stepped time equals the alarm fields.
- R8: A write to any time counter (addresses 0 to 2) clears the sub-tick phase, so the next step needs `SUB_TICKS` fresh pulses. A counter write in the same cycle as a completing tick wins, and no step happens.
- R9: Register map: 0 half-seconds, 1 minutes, 2 hours, 3 alarm half-seconds, 4 alarm minutes, 5 alarm hours, 6 control. Address 7 reads 0.
- R10: Writing a value at or above a counter's or alarm field's modulus (120, 60, 24) loads 0 into that field.
- R11: Interval selections 0, 6 and 7 produce no interval interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled tick enable, one cycle per pulse |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_interval | output | 1 | Periodic interval interrupt pulse |
| irq_alarm | output | 1 | Alarm match interrupt pulse |

## Verification
The interval interrupt and the alarm interrupt can both fire on the same step. The bench provokes this by setting the alarm to midnight, selecting the daily interval and stepping from 23:59 half 119. It judges the result by sampling both outputs high in the same cycle and both low in the next. A second collision pairs a counter write with the tick that would complete a half-second. That case is judged by reading back the written value and then counting a full set of fresh ticks before the next step.

// File: rtl/tod_alarm_clock.sv
module tod_alarm_clock #(
  parameter int SUB_TICKS    = 4,
  parameter int HALF_PER_MIN = 120,
  parameter int MIN_PER_HOUR = 60,
  parameter int HOUR_PER_DAY = 24,
  parameter int DW           = 8,
  parameter int AW           = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_interval,
  output logic          irq_alarm
);
  localparam int SW  = (SUB_TICKS > 2) ? $clog2(SUB_TICKS) : 1;
  localparam int HW  = $clog2(HALF_PER_MIN);
  localparam int MW  = $clog2(MIN_PER_HOUR);
  localparam int RW  = $clog2(HOUR_PER_DAY);
  localparam logic [2:0] SEL_HALF = 3'd1, SEL_SEC = 3'd2, SEL_MIN = 3'd3,
                         SEL_HOUR = 3'd4, SEL_DAY = 3'd5;

  logic [SW-1:0] sub;
  logic [HW-1:0] half, al_half, nxt_half;
  logic [MW-1:0] mins, al_min, nxt_min;
  logic [RW-1:0] hour, al_hour, nxt_hour;
  logic [2:0]    int_sel;
  logic          al_en;

  wire wr_half = reg_wr && reg_addr == AW'(0);
  wire wr_min  = reg_wr && reg_addr == AW'(1);
  wire wr_hour = reg_wr && reg_addr == AW'(2);
  wire cnt_wr  = wr_half | wr_min | wr_hour;
  wire sub_end = sub == SW'(SUB_TICKS - 1);
  wire step    = tick_en && sub_end && !cnt_wr;

  wire half_wrap = half == HW'(HALF_PER_MIN - 1);
  wire min_wrap  = mins == MW'(MIN_PER_HOUR - 1);
  wire hour_wrap = hour == RW'(HOUR_PER_DAY - 1);

  assign nxt_half = half_wrap ? '0 : half + HW'(1);
  assign nxt_min  = !half_wrap ? mins : (min_wrap ? '0 : mins + MW'(1));
  assign nxt_hour = !(half_wrap && min_wrap) ? hour : (hour_wrap ? '0 : hour + RW'(1));

  wire ok_half = reg_wdata < DW'(HALF_PER_MIN);
  wire ok_min  = reg_wdata < DW'(MIN_PER_HOUR);
  wire ok_hour = reg_wdata < DW'(HOUR_PER_DAY);
  wire [HW-1:0] w_half = ok_half ? reg_wdata[HW-1:0] : '0;
  wire [MW-1:0] w_min  = ok_min  ? reg_wdata[MW-1:0] : '0;
  wire [RW-1:0] w_hour = ok_hour ? reg_wdata[RW-1:0] : '0;

  logic int_hit;
  always_comb begin
    case (int_sel)
      SEL_HALF: int_hit = 1'b1;
      SEL_SEC:  int_hit = half[0];
      SEL_MIN:  int_hit = half_wrap;
      SEL_HOUR: int_hit = half_wrap && min_wrap;
      SEL_DAY:  int_hit = half_wrap && min_wrap && hour_wrap;
      default:  int_hit = 1'b0;
    endcase
  end

  wire al_hit = al_en && nxt_half == al_half && nxt_min == al_min && nxt_hour == al_hour;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub <= '0;
    end else if (cnt_wr) begin
      sub <= '0;
    end else if (tick_en) begin
      sub <= sub_end ? '0 : sub + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half <= '0;
      mins <= '0;
      hour <= '0;
      irq_interval <= 1'b0;
      irq_alarm    <= 1'b0;
    end else begin
      irq_interval <= step && int_hit;
      irq_alarm    <= step && al_hit;
      if (step) begin
        half <= nxt_half;
        mins <= nxt_min;
        hour <= nxt_hour;
      end
      if (wr_half) half <= w_half;
      if (wr_min)  mins <= w_min;
      if (wr_hour) hour <= w_hour;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_half <= '0;
      al_min  <= '0;
      al_hour <= '0;
      int_sel <= '0;
      al_en   <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        AW'(3): al_half <= w_half;
        AW'(4): al_min  <= w_min;
        AW'(5): al_hour <= w_hour;
        AW'(6): {al_en, int_sel} <= reg_wdata[3:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      AW'(0):  reg_rdata = DW'(half);
      AW'(1):  reg_rdata = DW'(mins);
      AW'(2):  reg_rdata = DW'(hour);
      AW'(3):  reg_rdata = DW'(al_half);
      AW'(4):  reg_rdata = DW'(al_min);
      AW'(5):  reg_rdata = DW'(al_hour);
      AW'(6):  reg_rdata = DW'({al_en, int_sel});
      default: reg_rdata = '0;
    endcase
  end

  // R3: counters stay inside their ranges
  p_half_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    half < HW'(HALF_PER_MIN));
  p_min_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mins < MW'(MIN_PER_HOUR));
  p_hour_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hour < RW'(HOUR_PER_DAY));

  // R2: without a completed tick or a write, the time holds
  p_time_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !cnt_wr) |=> $stable({hour, mins, half}));

  // R4: the interval interrupt is a single-cycle pulse
  p_int_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_interval |=> !irq_interval);

  // R5: the daily pulse only appears at midnight
  p_day_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_interval && $past(int_sel) == SEL_DAY) |-> (half == '0 && mins == '0 && hour == '0));

  // R6: an alarm pulse shows the alarm time and lasts one cycle
  p_alarm_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_alarm |-> (half == al_half && mins == al_min && hour == al_hour));
  p_alarm_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_alarm |=> !irq_alarm);
endmodule

// File: tb/tod_alarm_clock_tb.sv
module tod_alarm_clock_tb;
  localparam int SUB = 4;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_interval, irq_alarm;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  tod_alarm_clock #(.SUB_TICKS(SUB)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_interval(irq_interval), .irq_alarm(irq_alarm));

  // {sel[3], hour[5], min[6], half[7], expected interval pulse[1]}
  localparam int NV = 11;
  localparam logic [21:0] VEC [NV] = '{
    {3'd1, 5'd0,  6'd0,  7'd0,   1'b1},
    {3'd2, 5'd0,  6'd0,  7'd0,   1'b0},
    {3'd2, 5'd0,  6'd0,  7'd1,   1'b1},
    {3'd3, 5'd0,  6'd5,  7'd118, 1'b0},
    {3'd3, 5'd0,  6'd5,  7'd119, 1'b1},
    {3'd4, 5'd3,  6'd59, 7'd119, 1'b1},
    {3'd4, 5'd3,  6'd58, 7'd119, 1'b0},
    {3'd5, 5'd23, 6'd59, 7'd119, 1'b1},
    {3'd5, 5'd12, 6'd59, 7'd119, 1'b0},
    {3'd0, 5'd0,  6'd0,  7'd0,   1'b0},
    {3'd6, 5'd23, 6'd59, 7'd119, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = 3'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = 3'(a);
    #1 v = int'(reg_rdata);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
    end
  endtask

  task automatic set_time(input int h, input int m, input int s);
    wr(2, h); wr(1, m); wr(0, s);
  endtask

  function automatic int t_pack(input int h, input int m, input int s);
    return h * 10000 + m * 100 + s;
  endfunction

  task automatic rd_time(output int t);
    int h, m, s;
    rd(2, h); rd(1, m); rd(0, s);
    t = t_pack(h, m, s);
  endtask

  function automatic int t_next(input int h, input int m, input int s);
    int hh = h, mm = m, ss = s + 1;
    if (ss == 120) begin
      ss = 0; mm++;
      if (mm == 60) begin
        mm = 0; hh = (hh + 1) % 24;
      end
    end
    return t_pack(hh, mm, ss);
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R9 register map
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      check(v == 0, "R1 reset register", v, 0);
    end
    check(irq_interval == 0 && irq_alarm == 0, "R1 irqs low", int'(irq_interval | irq_alarm), 0);

    // R4 R5 R11 table of interval cases, R3 carry chain
    for (int i = 0; i < NV; i++) begin
      int sel, h, m, s, e, g;
      {sel, h, m, s, e} = {29'd0, VEC[i][21:19], 27'd0, VEC[i][18:14],
                           26'd0, VEC[i][13:8], 25'd0, VEC[i][7:1], 31'd0, VEC[i][0]};
      wr(6, sel);
      set_time(h, m, s);
      ticks(SUB);
      g = int'(irq_interval);
      check(g == e, "R4 interval pulse", g, e);
      check(irq_alarm == 0, "R7 no alarm when disabled", int'(irq_alarm), 0);
      @(negedge clk);
      check(irq_interval == 0, "R4 one-cycle pulse", int'(irq_interval), 0);
      rd_time(t);
      check(t == t_next(h, m, s), "R3 stepped time", t, t_next(h, m, s));
    end
    wr(6, 0);

    // R2 hold and exact tick count
    set_time(4, 10, 20);
    repeat (20) @(negedge clk);
    ticks(SUB - 1);
    rd(0, v);
    check(v == 20, "R2 no step before full tick count", v, 20);
    ticks(1);
    rd(0, v);
    check(v == 21, "R2 step on last tick", v, 21);

    // R8 write clears phase
    ticks(2);
    wr(1, 30);
    ticks(SUB - 1);
    rd(0, v);
    check(v == 21, "R8 phase cleared by write", v, 21);
    ticks(1);
    rd(0, v);
    check(v == 22, "R8 step after fresh ticks", v, 22);

    // R8 write collides with completing tick
    ticks(SUB - 1);
    @(negedge clk);
    tick_en = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'd50;
    @(negedge clk);
    tick_en = 1'b0; reg_wr = 1'b0;
    rd(0, v);
    check(v == 50, "R8 write wins over tick", v, 50);
    ticks(SUB - 1);
    rd(0, v);
    check(v == 50, "R8 no step after collision", v, 50);
    ticks(1);
    rd(0, v);
    check(v == 51, "R8 step after collision", v, 51);

    // R10 out-of-range writes
    wr(0, 120); rd(0, v); check(v == 0, "R10 half 120 loads 0", v, 0);
    wr(1, 60);  rd(1, v); check(v == 0, "R10 minute 60 loads 0", v, 0);
    wr(2, 24);  rd(2, v); check(v == 0, "R10 hour 24 loads 0", v, 0);
    wr(4, 75);  rd(4, v); check(v == 0, "R10 alarm minute 75 loads 0", v, 0);
    wr(1, 59);  rd(1, v); check(v == 59, "R10 minute 59 kept", v, 59);

    // R9 alarm and control readback, unused address
    wr(3, 4); wr(4, 1); wr(5, 0); wr(6, 8);
    rd(3, v); check(v == 4, "R9 alarm half readback", v, 4);
    rd(6, v); check(v == 8, "R9 control readback", v, 8);
    rd(7, v); check(v == 0, "R9 address 7 reads 0", v, 0);

    // R6 alarm match single pulse
    set_time(0, 1, 3);
    ticks(SUB);
    check(irq_alarm == 1, "R6 alarm on match", int'(irq_alarm), 1);
    check(irq_interval == 0, "R11 no interval with sel 0", int'(irq_interval), 0);
    @(negedge clk);
    check(irq_alarm == 0, "R6 alarm one cycle", int'(irq_alarm), 0);
    ticks(SUB - 1);
    check(irq_alarm == 0, "R6 no repeat in same half-second", int'(irq_alarm), 0);
    ticks(1);
    check(irq_alarm == 0, "R6 no alarm past match", int'(irq_alarm), 0);

    // R7 disabled alarm
    wr(6, 0);
    set_time(0, 1, 3);
    ticks(SUB);
    check(irq_alarm == 0, "R7 disabled alarm silent", int'(irq_alarm), 0);

    // R5 R6 collision: daily interval and alarm at midnight
    wr(3, 0); wr(4, 0); wr(5, 0); wr(6, 8 + 5);
    set_time(23, 59, 119);
    ticks(SUB);
    check(irq_alarm == 1 && irq_interval == 1, "R5 R6 both pulse at midnight",
          int'({irq_alarm, irq_interval}), 3);
    @(negedge clk);
    check(irq_alarm == 0 && irq_interval == 0, "R5 R6 both drop",
          int'({irq_alarm, irq_interval}), 0);
    rd_time(t);
    check(t == 0, "R3 day wrap to midnight", t, 0);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(6, v); check(v == 0, "R1 control after reset", v, 0);
    rd(3, v); check(v == 0, "R1 alarm after reset", v, 0);

    finish_run();
  end
endmodule